// File: doc/BRIEF.md
# Freezable Trace Capture Ring

The block records a 256-bit status word into an on-chip ring buffer on every clock cycle. The write pointer advances by one entry per cycle and wraps at the buffer depth. Capture can be frozen so that the stored history stays stable while it is read out.

Readout goes through two independent register ports. One is on the processor's special-register path and answers to register numbers 724 (control) and 725 (data). The other is on a debug-bus path and uses a one-bit address (0 for control, 1 for data). Each port has its own read pointer and its own freeze flag. Capture stops while either freeze flag is set.

A data read returns one 64-bit lane of a stored entry and steps that port's read pointer. A control read shows the write pointer, the freeze flag and the read pointer. The buffer depth is ORed into the write-pointer field, so software can recover the depth from the leading-zero count.

Top module: `tracelog_ring`

## Requirements
- R1: On each cycle that capture is enabled, `trace_i` is stored at the entry the write pointer names, and the write pointer increments modulo DEPTH (DEPTH is a power of two).
- R2: A control read returns a 64-bit word. Bits 63:32 hold DEPTH ORed with the write pointer, so the length bit sits at bit log2(DEPTH) of the upper word. Bit 31 is that port's freeze flag. Bits 30:0 hold that port's read pointer, zero-extended.
- R3: A data read returns the 64-bit lane selected by read pointer bits 1:0 (lane 0 = entry bits 63:0, lane 3 = bits 255:192) of the entry selected by the read-pointer bits above those. The read pointer counts 64-bit words and increments by one modulo 4×DEPTH on the cycle the strobe is taken.
- R4: A control write loads the read pointer from `wdata[log2(4×DEPTH)-1:0]` and the freeze flag from `wdata[31]`. All other written bits are ignored, and the write pointer is not changed.
- R5: While either port's freeze flag is set, no entry is written and the write pointer holds. A flag written at one clock edge takes effect for capture at the next edge.
- R6: The processor port acts only on register number 724 (control) and 725 (data). Any other number gives no response and changes no state.
- R7: The debug port uses `dbg_addr` 0 for control and 1 for data. Its read pointer and freeze flag are independent of the processor port's, and both ports may read in the same cycle.
- R8: After reset the write pointer, both read pointers and both freeze flags are zero, and both `*_rvalid` outputs are low.
- R9: Every read answers with `*_rvalid` high exactly one cycle after the strobe, with `*_rdata` valid in that cycle; otherwise `*_rdata` is zero. A data read of the entry being captured in the same cycle returns that entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trace_i | input | ENTRY_W | Status word captured each cycle |
| cpu_num | input | NUM_W | Processor special-register number |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 64 | Processor write data |
| cpu_rdata | output | 64 | Processor read response |
| cpu_rvalid | output | 1 | Processor response valid |
| dbg_addr | input | 1 | Debug register select: 0 control, 1 data |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Debug read response |
| dbg_rvalid | output | 1 | Debug response valid |

## Verification
The bench builds the block with DEPTH = 8. That gives a 3-bit write pointer with the length bit at bit 3 of the upper word, and a 5-bit read pointer. The write pointer wraps within a few cycles, and a 34-read run crosses the read-pointer wrap of 32 words. The small depth also lets the bench aim a read at the very entry being written in that cycle. Written values with junk above bit 4 and in bits 63:32 test the bits a control write must ignore.

// File: rtl/tlog_pkg.sv
package tlog_pkg;
  localparam int WORD_W  = 64;
  localparam int FRZ_BIT = 31;

  // upper control word: depth marker ORed into the write pointer
  function automatic logic [31:0] wp_field(int unsigned depth, logic [31:0] ptr);
    return 32'(depth) | ptr;
  endfunction

  function automatic logic [63:0] pack_ctl(logic [31:0] upper, logic frz, logic [30:0] rp);
    return {upper, frz, rp};
  endfunction
endpackage

// File: rtl/tlog_ram.sv
module tlog_ram #(
  parameter int AW  = 11,
  parameter int W   = 256,
  parameter int NRD = 2
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first ports: a same-cycle write is not seen (R9)
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [W-1:0] q_r;
    always_ff @(posedge clk) q_r <= mem[raddr[g]];
    assign rdata[g] = q_r;
  end
endmodule

// File: rtl/tlog_capture.sv
module tlog_capture #(
  parameter int EAW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frozen,
  output logic           we,
  output logic [EAW-1:0] wp
);
  assign we = rst_n & ~frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wp <= '0;
    else if (!frozen) wp <= wp + EAW'(1);
  end

  // R1
  wp_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |=> wp == $past(wp) + EAW'(1));

  // R5
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(wp));
endmodule

// File: rtl/tlog_port.sv
module tlog_port
  import tlog_pkg::*;
#(
  parameter int ENTRY_W = 256,
  parameter int EAW     = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_ctl,
  input  logic               sel_dat,
  input  logic               rd,
  input  logic               wr,
  input  logic [63:0]        wdata,
  input  logic [31:0]        upper,
  output logic [EAW-1:0]     ram_addr,
  input  logic [ENTRY_W-1:0] ram_q,
  output logic [63:0]        rdata,
  output logic               rvalid,
  output logic               frz
);
  localparam int LANES = ENTRY_W / WORD_W;
  localparam int LW    = $clog2(LANES);
  localparam int RPW   = EAW + LW;

  logic [RPW-1:0] rp;
  logic           frz_q;
  logic           rv_q, is_dat_q;
  logic [LW-1:0]  lane_q;
  logic [63:0]    ctl_q;

  // named events for the assertions
  logic ctl_wr, dat_rd, any_rd;
  assign ctl_wr = wr & sel_ctl;
  assign dat_rd = rd & sel_dat & ~ctl_wr;
  assign any_rd = rd & (sel_ctl | sel_dat);

  logic [63:0] ctl_view;
  assign ctl_view = pack_ctl(upper, frz_q, 31'(rp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      frz_q <= 1'b0;
    end else if (ctl_wr) begin
      rp    <= wdata[RPW-1:0];
      frz_q <= wdata[FRZ_BIT];
    end else if (dat_rd) begin
      rp    <= rp + RPW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q     <= 1'b0;
      is_dat_q <= 1'b0;
      lane_q   <= '0;
      ctl_q    <= '0;
    end else begin
      rv_q     <= any_rd;
      is_dat_q <= sel_dat;
      lane_q   <= rp[LW-1:0];
      ctl_q    <= ctl_view;
    end
  end

  logic [63:0] lane_w [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = ram_q[g*WORD_W +: WORD_W];
  end

  assign ram_addr = rp[RPW-1:LW];
  assign rvalid   = rv_q;
  assign frz      = frz_q;
  assign rdata    = !rv_q ? 64'd0 : (is_dat_q ? lane_w[lane_q] : ctl_q);

  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_rd |=> rvalid);

  // R6
  no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rd |=> !rvalid && rdata == 64'd0);

  // R3
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> rp == $past(rp) + RPW'(1));

  // R4
  rp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> rp == $past(wdata[RPW-1:0]) && frz_q == $past(wdata[FRZ_BIT]));

  // R4
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(frz_q));
endmodule

// File: rtl/tracelog_ring.sv
module tracelog_ring
  import tlog_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int ENTRY_W = 256,
  parameter int NUM_W   = 10,
  parameter int CTL_NUM = 724,
  parameter int DAT_NUM = 725
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRY_W-1:0] trace_i,
  input  logic [NUM_W-1:0]   cpu_num,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [63:0]        cpu_wdata,
  output logic [63:0]        cpu_rdata,
  output logic               cpu_rvalid,
  input  logic               dbg_addr,
  input  logic               dbg_rd,
  input  logic               dbg_wr,
  input  logic [63:0]        dbg_wdata,
  output logic [63:0]        dbg_rdata,
  output logic               dbg_rvalid
);
  localparam int EAW = $clog2(DEPTH);
  localparam int NP  = 2;

  logic [EAW-1:0] wp;
  logic           we;
  logic           cpu_frz, dbg_frz, frozen;
  logic [31:0]    upper;

  assign frozen = cpu_frz | dbg_frz;
  assign upper  = wp_field(DEPTH, 32'(wp));

  tlog_capture #(.EAW(EAW)) u_cap (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .we(we), .wp(wp)
  );

  logic [NP-1:0][EAW-1:0]     raddr;
  logic [NP-1:0][ENTRY_W-1:0] rq;

  tlog_ram #(.AW(EAW), .W(ENTRY_W), .NRD(NP)) u_ram (
    .clk(clk), .we(we), .waddr(wp), .wdata(trace_i), .raddr(raddr), .rdata(rq)
  );

  // R6: processor path decodes its two register numbers
  logic cpu_sel_ctl, cpu_sel_dat;
  assign cpu_sel_ctl = (cpu_num == NUM_W'(CTL_NUM));
  assign cpu_sel_dat = (cpu_num == NUM_W'(DAT_NUM));

  tlog_port #(.ENTRY_W(ENTRY_W), .EAW(EAW)) u_cpu (
    .clk(clk), .rst_n(rst_n), .sel_ctl(cpu_sel_ctl), .sel_dat(cpu_sel_dat),
    .rd(cpu_rd), .wr(cpu_wr), .wdata(cpu_wdata), .upper(upper),
    .ram_addr(raddr[0]), .ram_q(rq[0]), .rdata(cpu_rdata),
    .rvalid(cpu_rvalid), .frz(cpu_frz)
  );

  // R7: debug path, one address bit
  tlog_port #(.ENTRY_W(ENTRY_W), .EAW(EAW)) u_dbg (
    .clk(clk), .rst_n(rst_n), .sel_ctl(~dbg_addr), .sel_dat(dbg_addr),
    .rd(dbg_rd), .wr(dbg_wr), .wdata(dbg_wdata), .upper(upper),
    .ram_addr(raddr[1]), .ram_q(rq[1]), .rdata(dbg_rdata),
    .rvalid(dbg_rvalid), .frz(dbg_frz)
  );

  // R5
  freeze_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_frz || dbg_frz) |-> !we);
endmodule

// File: tb/tracelog_ring_tb.sv
module tracelog_ring_tb;
  localparam int DEPTH = 8;
  localparam int RPM   = 4 * DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [255:0] trace_i = '0;
  logic [9:0]  cpu_num = '0;
  logic        cpu_rd = 0, cpu_wr = 0;
  logic [63:0] cpu_wdata = '0;
  logic [63:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        dbg_addr = 0, dbg_rd = 0, dbg_wr = 0;
  logic [63:0] dbg_wdata = '0;
  logic [63:0] dbg_rdata;
  logic        dbg_rvalid;

  always #10 clk = ~clk;

  tracelog_ring #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .trace_i(trace_i),
    .cpu_num(cpu_num), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .dbg_addr(dbg_addr), .dbg_rd(dbg_rd), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid)
  );

  int errors = 0, checks = 0, cyc = 0;
  string phase_tag = "R8";
  bit done = 0;

  function automatic logic [255:0] mk_trace(int c);
    logic [255:0] t;
    for (int k = 0; k < 4; k++) t[k*64 +: 64] = {32'(c), 16'hBEEF, 16'(k)};
    return t;
  endfunction

  // behavioural reference model
  logic [255:0] m_mem [DEPTH];
  int m_wp = 0, m_rpc = 0, m_rpd = 0;
  bit m_fc = 0, m_fd = 0, model_ok = 0;
  bit e_cv = 0, e_dv = 0;
  logic [63:0] e_cd = '0, e_dd = '0;

  function automatic logic [63:0] m_ctl(int rp, bit fz);
    return {32'(DEPTH) | 32'(m_wp), fz, 31'(rp)};
  endfunction
  function automatic logic [63:0] m_word(int rp);
    return m_mem[rp / 4][(rp % 4) * 64 +: 64];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_wp = 0; m_rpc = 0; m_rpd = 0; m_fc = 0; m_fd = 0;
      e_cv = 0; e_dv = 0; e_cd = '0; e_dd = '0; model_ok = 1;
    end else begin
      bit frz_now;
      frz_now = m_fc | m_fd;
      e_cv = 0; e_cd = '0; e_dv = 0; e_dd = '0;
      if (cpu_rd && cpu_num == 10'd724) begin e_cv = 1; e_cd = m_ctl(m_rpc, m_fc); end
      if (cpu_rd && cpu_num == 10'd725) begin e_cv = 1; e_cd = m_word(m_rpc); end
      if (dbg_rd && !dbg_addr) begin e_dv = 1; e_dd = m_ctl(m_rpd, m_fd); end
      if (dbg_rd && dbg_addr)  begin e_dv = 1; e_dd = m_word(m_rpd); end
      if (cpu_wr && cpu_num == 10'd724) begin
        m_rpc = int'(cpu_wdata[4:0]); m_fc = cpu_wdata[31];
      end else if (cpu_rd && cpu_num == 10'd725) m_rpc = (m_rpc + 1) % RPM;
      if (dbg_wr && !dbg_addr) begin
        m_rpd = int'(dbg_wdata[4:0]); m_fd = dbg_wdata[31];
      end else if (dbg_rd && dbg_addr) m_rpd = (m_rpd + 1) % RPM;
      if (!frz_now) begin
        m_mem[m_wp] = trace_i;
        m_wp = (m_wp + 1) % DEPTH;
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", phase_tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    trace_i <= mk_trace(cyc);
    if (model_ok && !done) begin
      chk("cpu_rvalid", 64'(cpu_rvalid), 64'(e_cv));
      chk("cpu_rdata",  cpu_rdata, e_cd);
      chk("dbg_rvalid", 64'(dbg_rvalid), 64'(e_dv));
      chk("dbg_rdata",  dbg_rdata, e_dd);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  task automatic step();
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0; dbg_rd = 0; dbg_wr = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic cpu_set(bit r, bit w, int num, logic [63:0] d);
    cpu_rd = r; cpu_wr = w; cpu_num = 10'(num); cpu_wdata = d;
  endtask
  task automatic dbg_set(bit r, bit w, bit a, logic [63:0] d);
    dbg_rd = r; dbg_wr = w; dbg_addr = a; dbg_wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: reset values seen through control reads
    phase_tag = "R8";
    cpu_set(1, 0, 724, '0); dbg_set(1, 0, 0, '0); step();
    idle(1);
    // R1 / R2: capture running, wp visible with length bit
    phase_tag = "R1";
    idle(12);
    cpu_set(1, 0, 724, '0); step();
    idle(3);
    phase_tag = "R2";
    dbg_set(1, 0, 0, '0); step();
    idle(1);
    // R5: freeze from either port halts capture
    phase_tag = "R5";
    cpu_set(0, 1, 724, 64'h8000_0000); step();
    idle(3);
    cpu_set(1, 0, 724, '0); step();
    dbg_set(0, 1, 0, 64'h8000_0000); step();
    cpu_set(0, 1, 724, 64'h0); step();
    idle(2);
    dbg_set(1, 0, 0, '0); cpu_set(1, 0, 724, '0); step();
    cpu_set(0, 1, 724, 64'h8000_0000); dbg_set(0, 1, 0, 64'h0); step();
    idle(2);
    // R3: readout of every word, across the read-pointer wrap
    phase_tag = "R3";
    for (int i = 0; i < RPM + 2; i++) begin cpu_set(1, 0, 725, '0); step(); end
    cpu_set(1, 0, 724, '0); step();
    idle(1);
    // R4: control write loads rp and freeze, ignores other bits, keeps wp
    phase_tag = "R4";
    cpu_set(0, 1, 724, 64'hFFFF_FFE0_8000_0FE5); step();
    cpu_set(1, 0, 724, '0); step();
    cpu_set(1, 0, 725, '0); step();
    cpu_set(1, 0, 725, '0); step();
    cpu_set(1, 0, 724, '0); step();
    // R7: independent debug pointer, simultaneous reads
    phase_tag = "R7";
    dbg_set(0, 1, 0, 64'h0000_0000_0000_0009); step();
    for (int i = 0; i < 4; i++) begin
      dbg_set(1, 0, 1, '0); cpu_set(1, 0, 725, '0); step();
    end
    dbg_set(1, 0, 0, '0); cpu_set(1, 0, 724, '0); step();
    // R6: other register numbers are ignored
    phase_tag = "R6";
    cpu_set(1, 0, 723, '0); step();
    cpu_set(0, 1, 726, 64'h8000_0013); step();
    cpu_set(0, 1, 0, 64'h0000_0007); step();
    cpu_set(1, 0, 724, '0); step();
    idle(1);
    // R9: read aimed at the entry captured in that same cycle
    phase_tag = "R9";
    cpu_set(0, 1, 724, 64'h0); step();
    idle(2);
    dbg_set(0, 1, 0, 64'((((m_wp + 1) % DEPTH) * 4))); step();
    for (int i = 0; i < 4; i++) begin dbg_set(1, 0, 1, '0); step(); end
    idle(2);
    finish_run();
  end
endmodule